// File: doc/BRIEF.md
# Integer Status Flag Generator

This block is a registered integer arithmetic and logic unit. A caller presents two operands and an operation code with a valid strobe. One clock later the block returns the result, a six-bit status word and an output valid. The operations are add, subtract, bitwise AND, bitwise OR and bitwise XOR, on a parameterised width that defaults to 32 bits.

The status word carries the usual unsigned carry, signed overflow, sign and zero indications. It also carries two extras: an auxiliary carry taken at the boundary between bit 3 and bit 4, and a parity indication computed over the low byte of the result. Downstream logic samples the status word as it would a processor condition register. Between valid operations, the result and the status word keep their last values.

Top module: `alu_flag_unit`

## Requirements
- R1: With op_i = 0 (add), result_o is (a_i + b_i) modulo 2^WIDTH, and flag bit 0 (carry) is set exactly when the unsigned sum exceeds 2^WIDTH - 1.
- R2: With op_i = 1 (subtract), result_o is (a_i - b_i) modulo 2^WIDTH, and flag bit 0 (carry) is set exactly when b_i is larger than a_i as unsigned numbers (a borrow).
- R3: Flag bit 5 (overflow) is set for add or subtract exactly when the true signed result does not fit in WIDTH bits in two's complement.
- R4: Flag bit 4 (sign) equals the most significant bit of result_o after every valid operation.
- R5: Flag bit 3 (zero) is set exactly when every bit of result_o is 0 after a valid operation.
- R6: Flag bit 2 (auxiliary carry) is set on add when a carry passes from bit 3 into bit 4, and on subtract when the low nibble of a_i is smaller than the low nibble of b_i (a borrow into bit 3).
- R7: Flag bit 1 (parity) is set when result_o[7:0] holds an even number of 1 bits. Bits above bit 7 do not affect it.
- R8: With op_i = 2, 3 or 4, result_o is a_i AND, OR or XOR b_i respectively, and the carry, overflow and auxiliary carry flags are cleared.
- R9: Result, flags and valid_o appear on the first rising clock edge after valid_i is sampled high with a legal op_i. valid_o is high for one cycle per accepted operation.
- R10: When valid_i is low, result_o and flags_o keep their values and valid_o is low.
- R11: op_i values 5, 6 and 7 are ignored: result_o and flags_o are unchanged and valid_o stays low.
- R12: While rst_ni is low, result_o, flags_o and valid_o are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Operation strobe |
| op_i | input | 3 | Operation code: 0 add, 1 sub, 2 and, 3 or, 4 xor |
| a_i | input | WIDTH | First operand |
| b_i | input | WIDTH | Second operand (subtrahend for sub) |
| valid_o | output | 1 | Result and flags updated this cycle |
| result_o | output | WIDTH | Registered result |
| flags_o | output | 6 | {overflow, sign, zero, aux carry, parity, carry} |

## Verification
On every cycle, the assertions check how the registered flag word relates to the registered result: sign, zero and low-byte parity after each valid operation. They also check that carry, overflow and auxiliary carry are clear after a logical operation, that the outputs hold while no legal operation is strobed, and that valid_o follows the input strobe by one cycle. The arithmetic values themselves can only be shown by the bench's scenarios. These are carry out of the top bit, borrow, signed overflow in both directions and the nibble carry and borrow, each checked against operands whose outcome was worked out by hand. The same applies to ignored opcodes, reset and the choice of the low byte for parity.

// File: rtl/alu_flag_pkg.sv
package alu_flag_pkg;

  typedef enum logic [2:0] {
    OP_ADD = 3'd0,
    OP_SUB = 3'd1,
    OP_AND = 3'd2,
    OP_OR  = 3'd3,
    OP_XOR = 3'd4
  } op_e;

  localparam int FLAG_W     = 6;
  localparam int NIBBLE_W   = 4;
  localparam int PARITY_W   = 8;

  localparam int FB_CARRY   = 0;
  localparam int FB_PARITY  = 1;
  localparam int FB_AUX     = 2;
  localparam int FB_ZERO    = 3;
  localparam int FB_SIGN    = 4;
  localparam int FB_OVF     = 5;

  // field order matches FB_* bit positions
  typedef struct packed {
    logic ovf;
    logic sign;
    logic zero;
    logic aux;
    logic parity;
    logic carry;
  } flags_t;

endpackage

// File: rtl/alu_flag_arith.sv
module alu_flag_arith
  import alu_flag_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic             sub_i,
  output logic [WIDTH-1:0] res_o,
  output logic             carry_o,
  output logic             aux_o,
  output logic             ovf_o
);
  localparam int MSB = WIDTH - 1;

  logic [WIDTH-1:0]    b_eff;
  logic [WIDTH:0]      sum_full;
  logic [NIBBLE_W:0]   sum_nib;

  // subtract as a + ~b + 1; carry-outs invert to give borrows
  assign b_eff    = sub_i ? ~b_i : b_i;
  assign sum_full = {1'b0, a_i} + {1'b0, b_eff} + {{WIDTH{1'b0}}, sub_i};
  assign sum_nib  = {1'b0, a_i[NIBBLE_W-1:0]} + {1'b0, b_eff[NIBBLE_W-1:0]}
                  + {{NIBBLE_W{1'b0}}, sub_i};

  assign res_o   = sum_full[WIDTH-1:0];
  assign carry_o = sum_full[WIDTH] ^ sub_i;
  assign aux_o   = sum_nib[NIBBLE_W] ^ sub_i;
  assign ovf_o   = (a_i[MSB] == b_eff[MSB]) && (sum_full[MSB] != a_i[MSB]);

endmodule

// File: rtl/alu_flag_logic.sv
module alu_flag_logic
  import alu_flag_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  op_e              op_i,
  output logic [WIDTH-1:0] res_o
);
  always_comb begin
    unique case (op_i)
      OP_AND:  res_o = a_i & b_i;
      OP_OR:   res_o = a_i | b_i;
      default: res_o = a_i ^ b_i;
    endcase
  end
endmodule

// File: rtl/alu_flag_eval.sv
module alu_flag_eval
  import alu_flag_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] res_i,
  output logic             zero_o,
  output logic             sign_o,
  output logic             parity_o
);
  assign zero_o   = ~|res_i;
  assign sign_o   = res_i[WIDTH-1];
  assign parity_o = ~^res_i[PARITY_W-1:0];
endmodule

// File: rtl/alu_flag_unit.sv
module alu_flag_unit
  import alu_flag_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  valid_i,
  input  logic [2:0]            op_i,
  input  logic [WIDTH-1:0]      a_i,
  input  logic [WIDTH-1:0]      b_i,
  output logic                  valid_o,
  output logic [WIDTH-1:0]      result_o,
  output logic [FLAG_W-1:0]     flags_o
);
  op_e              op;
  logic             legal, is_arith, accept;
  logic [WIDTH-1:0] arith_res, logic_res, res_d;
  logic             arith_cf, arith_af, arith_of;
  logic             zf, sf, pf;
  flags_t           flags_d, flags_q;
  logic [WIDTH-1:0] result_q;
  logic             valid_q;

  assign op       = op_e'(op_i);
  assign legal    = (op_i <= 3'(OP_XOR));
  assign is_arith = (op == OP_ADD) || (op == OP_SUB);
  assign accept   = valid_i && legal;

  alu_flag_arith #(.WIDTH(WIDTH)) u_arith (
    .a_i    (a_i),
    .b_i    (b_i),
    .sub_i  (op == OP_SUB),
    .res_o  (arith_res),
    .carry_o(arith_cf),
    .aux_o  (arith_af),
    .ovf_o  (arith_of)
  );

  alu_flag_logic #(.WIDTH(WIDTH)) u_logic (
    .a_i  (a_i),
    .b_i  (b_i),
    .op_i (op),
    .res_o(logic_res)
  );

  assign res_d = is_arith ? arith_res : logic_res;

  alu_flag_eval #(.WIDTH(WIDTH)) u_eval (
    .res_i   (res_d),
    .zero_o  (zf),
    .sign_o  (sf),
    .parity_o(pf)
  );

  always_comb begin
    flags_d.ovf    = is_arith & arith_of;
    flags_d.sign   = sf;
    flags_d.zero   = zf;
    flags_d.aux    = is_arith & arith_af;
    flags_d.parity = pf;
    flags_d.carry  = is_arith & arith_cf;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q  <= 1'b0;
      result_q <= '0;
      flags_q  <= '0;
    end else begin
      valid_q <= accept;
      if (accept) begin
        result_q <= res_d;
        flags_q  <= flags_d;
      end
    end
  end

  assign valid_o  = valid_q;
  assign result_o = result_q;
  assign flags_o  = flags_q;

endmodule

// File: rtl/alu_flag_chk.sv
module alu_flag_chk
  import alu_flag_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              valid_i,
  input logic [2:0]        op_i,
  input logic              valid_o,
  input logic [WIDTH-1:0]  result_o,
  input logic [FLAG_W-1:0] flags_o
);
  logic accepted, logical;
  assign accepted = valid_i && (op_i <= 3'(OP_XOR));
  assign logical  = accepted && (op_i >= 3'(OP_AND));

  assert_sign_msb_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> flags_o[FB_SIGN] == result_o[WIDTH-1]);

  assert_zero_flag_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> flags_o[FB_ZERO] == (result_o == '0));

  assert_parity_low_byte_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> flags_o[FB_PARITY] == ~^result_o[PARITY_W-1:0]);

  assert_logic_clears_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    logical |=> !flags_o[FB_CARRY] && !flags_o[FB_OVF] && !flags_o[FB_AUX]);

  assert_valid_latency_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accepted |=> valid_o);

  assert_hold_idle_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o && $stable(result_o) && $stable(flags_o));

  assert_illegal_ignored_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i > 3'(OP_XOR)) |=> !valid_o && $stable(result_o) && $stable(flags_o));

endmodule

bind alu_flag_unit alu_flag_chk #(.WIDTH(WIDTH)) u_alu_flag_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .valid_i (valid_i),
  .op_i    (op_i),
  .valid_o (valid_o),
  .result_o(result_o),
  .flags_o (flags_o)
);

// File: tb/alu_flag_unit_test.sv
module alu_flag_unit_test;
  localparam int CLK_PERIOD = 10;
  localparam int W = 32;
  localparam int NVEC = 14;

  typedef struct packed {
    logic [2:0]   op;
    logic [W-1:0] a;
    logic [W-1:0] b;
    logic [W-1:0] res;
    logic [5:0]   fl;   // {ovf, sign, zero, aux, parity, carry}
  } vec_t;

  localparam vec_t VEC [NVEC] = '{
    '{3'd0, 32'h0000_0001, 32'h0000_0001, 32'h0000_0002, 6'b000000}, // R1 plain add
    '{3'd0, 32'hFFFF_FFFF, 32'h0000_0001, 32'h0000_0000, 6'b001111}, // R1 R5 R6 carry out
    '{3'd0, 32'h7FFF_FFFF, 32'h0000_0001, 32'h8000_0000, 6'b110110}, // R3 R4 pos overflow
    '{3'd1, 32'h0000_0005, 32'h0000_0007, 32'hFFFF_FFFE, 6'b010101}, // R2 R6 borrow
    '{3'd1, 32'h8000_0000, 32'h0000_0001, 32'h7FFF_FFFF, 6'b100110}, // R3 neg overflow
    '{3'd1, 32'h1234_5678, 32'h1234_5678, 32'h0000_0000, 6'b001010}, // R2 R5 equal
    '{3'd1, 32'h0000_0010, 32'h0000_0001, 32'h0000_000F, 6'b000110}, // R6 nibble borrow only
    '{3'd2, 32'hF0F0_F0F0, 32'hFF00_FF00, 32'hF000_F000, 6'b010010}, // R8 and
    '{3'd3, 32'h0000_0000, 32'h0000_0000, 32'h0000_0000, 6'b001010}, // R8 or zero
    '{3'd4, 32'hAAAA_AAAA, 32'h5555_5555, 32'hFFFF_FFFF, 6'b010010}, // R8 xor
    '{3'd4, 32'h0000_000F, 32'h0000_0008, 32'h0000_0007, 6'b000000}, // R7 odd parity
    '{3'd0, 32'h0000_0008, 32'h0000_0008, 32'h0000_0010, 6'b000100}, // R6 nibble carry
    '{3'd0, 32'h8000_0000, 32'h8000_0000, 32'h0000_0000, 6'b101011}, // R1 R3 carry+ovf
    '{3'd3, 32'h0000_0001, 32'h0000_0100, 32'h0000_0101, 6'b000000}  // R7 R8 low byte only
  };

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         valid_i = 1'b0;
  logic [2:0]   op_i = 3'd0;
  logic [W-1:0] a_i = '0;
  logic [W-1:0] b_i = '0;
  logic         valid_o;
  logic [W-1:0] result_o;
  logic [5:0]   flags_o;

  int n_checks = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  alu_flag_unit #(.WIDTH(W)) uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i), .op_i(op_i),
    .a_i(a_i), .b_i(b_i), .valid_o(valid_o), .result_o(result_o), .flags_o(flags_o)
  );

  task automatic check(input string req, input logic [W-1:0] got, input logic [W-1:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic drive(input logic v, input logic [2:0] op, input logic [W-1:0] a,
                       input logic [W-1:0] b);
    valid_i = v; op_i = op; a_i = a; b_i = b;
    @(negedge clk_i);
    valid_i = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk_i);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end

  initial begin
    logic [W-1:0] held_res;
    logic [5:0]   held_fl;
    repeat (3) @(negedge clk_i);
    // R12 reset state
    check("R12 result", result_o, '0);
    check("R12 flags", {26'd0, flags_o}, '0);
    check("R12 valid", {31'd0, valid_o}, '0);
    rst_ni = 1'b1;
    @(negedge clk_i);

    for (int i = 0; i < NVEC; i++) begin
      drive(1'b1, VEC[i].op, VEC[i].a, VEC[i].b);
      check($sformatf("R9 valid vec%0d", i), {31'd0, valid_o}, 32'd1);
      check($sformatf("R1 R2 R8 result vec%0d", i), result_o, VEC[i].res);
      check($sformatf("R3 R4 R5 R6 R7 flags vec%0d", i), {26'd0, flags_o}, {26'd0, VEC[i].fl});
    end

    // R9 valid_o is a single-cycle pulse
    @(negedge clk_i);
    check("R9 valid pulse", {31'd0, valid_o}, 32'd0);

    // set known state, then idle with different operands: R10
    drive(1'b1, 3'd1, 32'h0000_0005, 32'h0000_0007);
    held_res = result_o; held_fl = flags_o;
    check("R10 setup", held_res, 32'hFFFF_FFFE);
    drive(1'b0, 3'd0, 32'h0000_0000, 32'h0000_0000);
    check("R10 result held", result_o, held_res);
    check("R10 flags held", {26'd0, flags_o}, {26'd0, held_fl});
    check("R10 valid low", {31'd0, valid_o}, 32'd0);

    // R11 illegal opcodes
    for (int op = 5; op < 8; op++) begin
      drive(1'b1, 3'(op), 32'h0000_0000, 32'h0000_0000);
      check($sformatf("R11 result op%0d", op), result_o, held_res);
      check($sformatf("R11 flags op%0d", op), {26'd0, flags_o}, {26'd0, held_fl});
      check($sformatf("R11 valid op%0d", op), {31'd0, valid_o}, 32'd0);
    end

    // R8 logic after arithmetic that set carry/aux: clears them
    drive(1'b1, 3'd2, 32'hFFFF_FFFF, 32'h0000_0003);
    check("R8 and clears", {26'd0, flags_o}, {26'd0, 6'b000010});
    check("R8 and result", result_o, 32'h0000_0003);

    // R12 asynchronous reset mid-run
    #(CLK_PERIOD/4) rst_ni = 1'b0;
    #1;
    check("R12 async result", result_o, '0);
    check("R12 async flags", {26'd0, flags_o}, '0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end
endmodule